// File: doc/BRIEF.md
# Debug Halt Peripheral Freeze Controller

This block holds the debug-time configuration that decides two things. The first is whether the core and bus clocks keep running in the deep low-power modes. The second is which peripheral counters stop while the processor is halted by a debugger. It has four 32-bit registers behind a small request/response register port:

- a fixed identification word,
- a low-power keep-clock word,
- two freeze words.

Each freeze output is a stored stop bit gated by a synchronised copy of the core-halted status. A peripheral therefore stops counting only during a halt, and only when its stop bit is set.

The register port uses valid/ready in both directions. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. Exactly one response follows, which appears in the next cycle. The response is held unchanged until `rsp_ready_i` is high. `req_ready_o` is high when no response is pending, or when the pending response is leaving in the same cycle. Back-pressure on the response side therefore stalls new requests.

The writable registers are cleared only by the power-on reset `por_n`. No system reset reaches the block, so a debugger can program it while the rest of the chip is held in reset.

Top module: `dbg_freeze_ctl`

## Requirements
- R1: The register at byte offset 0x0 reads `{REV_ID[15:0], 4'b0110, DEV_ID[11:0]}`. A write to it completes with no error and leaves its value unchanged.
- R2: At offset 0x4, bit 1 drives `keep_clk_stop_o` and bit 2 drives `keep_clk_stby_o`. Both outputs follow the stored bits directly, whatever the halt state.
- R3: At offset 0x8, only bits 1, 4, 5, 10, 11, 12, 21 and 22 are writable. All other bits read 0.
- R4: At offset 0xC, only bits 11, 15, 16, 17 and 18 are writable. All other bits read 0.
- R5: Each bit of `frz_a_o` / `frz_b_o` is 1 exactly when the matching bit of the offset 0x8 / 0xC register is 1 and the synchronised halt is 1. While the core is not halted, every freeze output is 0.
- R6: A change on `core_halted_i` reaches the freeze outputs after exactly SYNC_STAGES rising clock edges. The default is 2.
- R7: A request whose byte strobes `req_be_i` are not all ones gets `rsp_err_o`=1 and `rsp_rdata_o`=0. If it is a write, it changes no register.
- R8: A request with `req_addr_i[1:0]` not equal to 00 gets `rsp_err_o`=1 and `rsp_rdata_o`=0. If it is a write, it changes no register.
- R9: Asserting `por_n` low clears all writable registers, and with them all keep-clock and freeze outputs, to 0.
- R10: The response appears in the cycle after a request is accepted. While `rsp_valid_o`=1 and `rsp_ready_i`=0, the response holds steady and `req_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port and synchroniser clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| core_halted_i | input | 1 | Core halted status, asynchronous |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Byte offset of the register |
| req_be_i | input | 4 | Byte strobes; all ones = full word |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response can be taken |
| rsp_rdata_o | output | 32 | Read data, 0 for writes and errors |
| rsp_err_o | output | 1 | Access error |
| keep_clk_stop_o | output | 1 | Keep clocks running in Stop mode |
| keep_clk_stby_o | output | 1 | Keep clocks running in Standby mode |
| frz_a_o | output | 32 | Freeze group A, per peripheral |
| frz_b_o | output | 32 | Freeze group B, per peripheral |

## Verification
The assertions assume a few things about the inputs:

- `por_n` is the only reset.
- Request fields are sampled only on the accepting edge.
- `core_halted_i` may change at any time, because it passes through the synchroniser before any check looks at it.

The stimulus drives every input shortly after a rising edge and samples outputs on the falling edge. It stalls the response side with a fixed ready pattern, plus one long hold, so the response-hold rule is exercised. Halt changes are made with no register access in flight, so the latency count can be checked edge by edge.

// File: rtl/dfz_pkg.sv
package dfz_pkg;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int BEW = DW / 8;

  localparam logic [DW-1:0] CFG_MASK = 32'h0000_0006;
  localparam logic [DW-1:0] GRPA_MASK = 32'h0060_1C32;
  localparam logic [DW-1:0] GRPB_MASK = 32'h0007_8800;
  localparam logic [3:0] ID_NIBBLE = 4'b0110;

  localparam int CFG_STOP_BIT = 1;
  localparam int CFG_STBY_BIT = 2;

  typedef enum logic [1:0] {
    SEL_ID  = 2'd0,
    SEL_CFG = 2'd1,
    SEL_GA  = 2'd2,
    SEL_GB  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dfz_halt_sync.sv
module dfz_halt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) sh[0] <= 1'b0;
          else        sh[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) sh[i] <= 1'b0;
          else        sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = sh[STAGES-1];
endmodule

// File: rtl/dfz_freeze_gate.sv
module dfz_freeze_gate #(
  parameter int W = 32
) (
  input  logic         halted_i,
  input  logic [W-1:0] stop_i,
  output logic [W-1:0] frz_o
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign frz_o[i] = stop_i[i] & halted_i;
    end
  endgenerate
endmodule

// File: rtl/dfz_regfile.sv
module dfz_regfile
  import dfz_pkg::*;
#(
  parameter logic [DW-1:0] GA_MASK = GRPA_MASK,
  parameter logic [DW-1:0] GB_MASK = GRPB_MASK
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr_en,
  input  reg_sel_e      wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] ga_q,
  output logic [DW-1:0] gb_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q <= '0;
      ga_q  <= '0;
      gb_q  <= '0;
    end else if (wr_en) begin
      unique case (wr_sel)
        SEL_CFG: cfg_q <= wr_data & CFG_MASK;
        SEL_GA:  ga_q  <= wr_data & GA_MASK;
        SEL_GB:  gb_q  <= wr_data & GB_MASK;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dfz_bus_if.sv
module dfz_bus_if
  import dfz_pkg::*;
(
  input  logic           clk,
  input  logic           por_n,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_write_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [BEW-1:0] req_be_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           rsp_valid_o,
  input  logic           rsp_ready_i,
  output logic [DW-1:0]  rsp_rdata_o,
  output logic           rsp_err_o,
  input  logic [DW-1:0]  id_val_i,
  input  logic [DW-1:0]  cfg_q_i,
  input  logic [DW-1:0]  ga_q_i,
  input  logic [DW-1:0]  gb_q_i,
  output logic           wr_en_o,
  output reg_sel_e       wr_sel_o,
  output logic [DW-1:0]  wr_data_o
);
  logic          accept;
  logic          full_word;
  logic          aligned;
  logic          legal;
  reg_sel_e      sel;
  logic [DW-1:0] rd_mux;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign full_word   = &req_be_i;
  assign aligned     = (req_addr_i[1:0] == 2'b00);
  assign legal       = full_word && aligned;
  assign sel         = reg_sel_e'(req_addr_i[3:2]);

  always_comb begin
    unique case (sel)
      SEL_ID:  rd_mux = id_val_i;
      SEL_CFG: rd_mux = cfg_q_i;
      SEL_GA:  rd_mux = ga_q_i;
      default: rd_mux = gb_q_i;
    endcase
  end

  assign wr_en_o   = accept && req_write_i && legal;
  assign wr_sel_o  = sel;
  assign wr_data_o = req_wdata_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_err_o   <= !legal;
      rsp_rdata_o <= (legal && !req_write_i) ? rd_mux : '0;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o))); // R10

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R10

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!por_n)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0)); // R7
endmodule

// File: rtl/dbg_freeze_ctl.sv
module dbg_freeze_ctl
  import dfz_pkg::*;
#(
  parameter logic [15:0]   REV_ID      = 16'h0002,
  parameter logic [11:0]   DEV_ID      = 12'h3A5,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] GA_MASK     = GRPA_MASK,
  parameter logic [DW-1:0] GB_MASK     = GRPB_MASK
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        core_halted_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [3:0]  req_addr_i,
  input  logic [3:0]  req_be_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [31:0] rsp_rdata_o,
  output logic        rsp_err_o,
  output logic        keep_clk_stop_o,
  output logic        keep_clk_stby_o,
  output logic [31:0] frz_a_o,
  output logic [31:0] frz_b_o
);
  localparam logic [DW-1:0] ID_VAL = {REV_ID, ID_NIBBLE, DEV_ID};

  logic          wr_en;
  reg_sel_e      wr_sel;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] cfg_q;
  logic [DW-1:0] ga_q;
  logic [DW-1:0] gb_q;
  logic          halted_s;

  dfz_bus_if u_bus (
    .clk         (clk),
    .por_n       (por_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_be_i    (req_be_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_err_o   (rsp_err_o),
    .id_val_i    (ID_VAL),
    .cfg_q_i     (cfg_q),
    .ga_q_i      (ga_q),
    .gb_q_i      (gb_q),
    .wr_en_o     (wr_en),
    .wr_sel_o    (wr_sel),
    .wr_data_o   (wr_data)
  );

  dfz_regfile #(.GA_MASK(GA_MASK), .GB_MASK(GB_MASK)) u_regs (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .ga_q    (ga_q),
    .gb_q    (gb_q)
  );

  dfz_halt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .por_n   (por_n),
    .async_i (core_halted_i),
    .sync_o  (halted_s)
  );

  dfz_freeze_gate #(.W(DW)) u_gate_a (
    .halted_i (halted_s),
    .stop_i   (ga_q),
    .frz_o    (frz_a_o)
  );

  dfz_freeze_gate #(.W(DW)) u_gate_b (
    .halted_i (halted_s),
    .stop_i   (gb_q),
    .frz_o    (frz_b_o)
  );

  assign keep_clk_stop_o = cfg_q[CFG_STOP_BIT];
  assign keep_clk_stby_o = cfg_q[CFG_STBY_BIT];

  AST_NARROW_NO_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid_i && req_ready_o && req_write_i && (req_be_i != 4'hF))
      |=> ($stable(cfg_q) && $stable(ga_q) && $stable(gb_q))); // R7

  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid_i && req_ready_o && req_write_i && (req_addr_i[1:0] != 2'b00))
      |=> ($stable(cfg_q) && $stable(ga_q) && $stable(gb_q))); // R8

  AST_FRZ_NEEDS_STOP: assert property (@(posedge clk) disable iff (!por_n)
    ((frz_a_o & ~ga_q) == '0) && ((frz_b_o & ~gb_q) == '0)); // R5

  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    ((ga_q & ~GA_MASK) == '0) && ((gb_q & ~GB_MASK) == '0)); // R3 R4
endmodule

// File: tb/sim_dbg_freeze_ctl.sv
module sim_dbg_freeze_ctl;
  localparam logic [31:0] ID_EXP = {16'h0002, 4'b0110, 12'h3A5};
  localparam logic [31:0] GA_M = 32'h0060_1C32;
  localparam logic [31:0] GB_M = 32'h0007_8800;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic core_halted = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic rsp_err;
  logic keep_stop, keep_stby;
  logic [31:0] frz_a, frz_b;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit hold = 1'b0;

  always #2 clk = ~clk;

  dbg_freeze_ctl u0 (
    .clk(clk), .por_n(por_n), .core_halted_i(core_halted),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .keep_clk_stop_o(keep_stop), .keep_clk_stby_o(keep_stby),
    .frz_a_o(frz_a), .frz_b_o(frz_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 rsp_ready = hold ? 1'b0 : ((cyc % 3) != 1);
  end

  // monitor: pops expected responses as they leave the design
  always @(negedge clk) begin
    if (por_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " data"}, rsp_rdata, e.data);
        check({e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
      end
    end
  end

  task automatic xfer(input bit wr, input logic [3:0] addr, input logic [3:0] be,
                      input logic [31:0] wd, input logic [31:0] ed, input bit ee,
                      input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk);
    e.data = ed; e.err = ee; e.tag = tag;
    sb.push_back(e);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && sb.size() != 0; i++) @(negedge clk);
    check("R10 queue drained", sb.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1;
    @(negedge clk);
    check("R9 reset frz_a", frz_a, 0);
    check("R9 reset frz_b", frz_b, 0);
    check("R9 reset keep", {30'd0, keep_stby, keep_stop}, 0);
    check("R10 reset rsp_valid", {31'd0, rsp_valid}, 0);

    // R1 identification
    xfer(0, 4'h0, 4'hF, 0, ID_EXP, 0, "R1 id read");
    xfer(1, 4'h0, 4'hF, 32'hFFFF_FFFF, 0, 0, "R1 id write");
    xfer(0, 4'h0, 4'hF, 0, ID_EXP, 0, "R1 id unchanged");
    // R2 configuration
    xfer(1, 4'h4, 4'hF, 32'hFFFF_FFFF, 0, 0, "R2 cfg write");
    xfer(0, 4'h4, 4'hF, 0, 32'h6, 0, "R2 cfg read");
    drain();
    check("R2 keep both", {30'd0, keep_stby, keep_stop}, 2'b11);
    xfer(1, 4'h4, 4'hF, 32'h4, 0, 0, "R2 cfg stby only");
    drain();
    check("R2 keep stby only", {30'd0, keep_stby, keep_stop}, 2'b10);
    // R3 R4 masks
    xfer(1, 4'h8, 4'hF, 32'hFFFF_FFFF, 0, 0, "R3 ga write");
    xfer(0, 4'h8, 4'hF, 0, GA_M, 0, "R3 ga read");
    xfer(1, 4'hC, 4'hF, 32'hFFFF_FFFF, 0, 0, "R4 gb write");
    xfer(0, 4'hC, 4'hF, 0, GB_M, 0, "R4 gb read");
    drain();
    check("R5 frz_a idle", frz_a, 0);
    check("R5 frz_b idle", frz_b, 0);

    // R6 latency on rise
    @(posedge clk); #1 core_halted = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 frz_a one edge", frz_a, 0);
    @(negedge clk);
    check("R6 frz_a two edges", frz_a, GA_M);
    check("R5 frz_b halted", frz_b, GB_M);
    check("R2 keep independent of halt", {30'd0, keep_stby, keep_stop}, 2'b10);
    xfer(1, 4'h8, 4'hF, 32'h0000_0012, 0, 0, "R5 ga partial");
    drain();
    check("R5 frz_a partial", frz_a, 32'h12);
    // R6 latency on fall
    @(posedge clk); #1 core_halted = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R6 frz_a still on", frz_a, 32'h12);
    @(negedge clk);
    check("R6 frz_a released", frz_a, 0);
    check("R6 frz_b released", frz_b, 0);

    // R7 narrow accesses
    xfer(1, 4'h8, 4'h3, 32'h0, 0, 1, "R7 narrow write");
    xfer(0, 4'h8, 4'hF, 0, 32'h12, 0, "R7 ga kept");
    xfer(0, 4'h0, 4'h1, 0, 0, 1, "R7 narrow read");
    // R8 misaligned accesses
    xfer(0, 4'h5, 4'hF, 0, 0, 1, "R8 misaligned read");
    xfer(1, 4'hD, 4'hF, 32'h0, 0, 1, "R8 misaligned write");
    xfer(0, 4'hC, 4'hF, 0, GB_M, 0, "R8 gb kept");
    drain();

    // R10 response hold under back-pressure
    @(posedge clk); #1 hold = 1'b1;
    xfer(0, 4'h0, 4'hF, 0, ID_EXP, 0, "R10 held read");
    repeat (3) @(negedge clk);
    check("R10 held valid", {31'd0, rsp_valid}, 1);
    check("R10 held ready low", {31'd0, req_ready}, 0);
    check("R10 held data", rsp_rdata, ID_EXP);
    @(posedge clk); #1 hold = 1'b0;
    drain();

    // R9 power-on reset clears
    xfer(1, 4'h4, 4'hF, 32'h6, 0, 0, "R9 cfg set");
    drain();
    @(posedge clk); #1 core_halted = 1'b1;
    repeat (3) @(negedge clk);
    #1 por_n = 1'b0;
    #1;
    check("R9 por frz_b", frz_b, 0);
    check("R9 por keep", {30'd0, keep_stby, keep_stop}, 0);
    @(posedge clk); #1 por_n = 1'b1; core_halted = 1'b0;
    xfer(0, 4'h8, 4'hF, 0, 0, 0, "R9 ga cleared");
    xfer(0, 4'hC, 4'hF, 0, 0, 0, "R9 gb cleared");
    xfer(0, 4'h4, 4'hF, 0, 0, 0, "R9 cfg cleared");
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule